// File: doc/BRIEF.md
# System Reset Control Port

This block is a single byte-wide control register on a simple I/O-port bus. It answers at one fixed legacy port address, 0xCF9. Firmware and the operating system write to this register to request a restart of the whole machine. Each bus transfer presents an address, a size in bytes, a write strobe with write data, and a read strobe. The block answers a read with read data in the same cycle, and it flags any access of the wrong size.

The register keeps the last legal byte written to it and returns that byte on reads. Bit 2 is the trigger: a legal write with bit 2 set produces a one-cycle reset request. The block drives this request in the same cycle the write is presented, so the surrounding reset sequencer can act on it at once. Bit 1 holds the reset-type choice (0 soft, 1 hard) and is only stored. The two types produce the same request. The value firmware tables advertise for a restart is 0x06, which sets both bits.

The stored byte returns to zero when the block's own reset is applied. After a system reset, software must write the register again with bit 2 set to ask for another restart.

Top module: `sys_reset_port`

## Requirements
- R1: While and immediately after `rst_n` is low, the stored byte is 0x00. A legal read then returns 0, and `io_err` and `sys_rst_req` are low.
- R2: An access whose full address differs from 0xCF9 (nearby ports and aliases that differ only in upper address bits included) has no effect. `io_err` stays low, `io_rdata` is 0, `sys_rst_req` stays low, and the stored byte is unchanged.
- R3: The `io_size` field gives the access width in bytes, and only the value 1 is legal. A read or write at 0xCF9 with any other size raises `io_err` in the same cycle. Such a write changes neither the stored byte nor `sys_rst_req`, and such a read returns 0.
- R4: A legal read (address 0xCF9, size 1) returns the stored byte zero-extended on `io_rdata` in the same cycle. When there is no legal read, `io_rdata` is 0.
- R5: A legal write stores `io_wdata[7:0]` at the clock edge that ends the cycle. Bits of `io_wdata` above bit 7 are ignored.
- R6: `sys_rst_req` is high in exactly those cycles that carry a legal write with `io_wdata[2]` set. Back-to-back such writes give one request cycle each.
- R7: Bit 1 is stored and read back but does not affect the request. A write of 0x02 gives no request, while 0x04 and 0x06 both give one.
- R8: A legal write with `io_wdata[2]` clear gives no request and only updates the stored byte.
- R9: When a legal read and a legal write occur in the same cycle, the read returns the byte stored before that write.
- R10: Writing the advertised restart value 0x06 requests a reset, and the register then reads back 0x06 until it is next written or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the stored byte |
| io_addr | input | ADDR_W (16) | I/O port address of the access |
| io_size | input | SIZE_W (3) | Access width in bytes |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | DATA_W (32) | Write data, low byte used |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | DATA_W (32) | Read data, stored byte zero-extended |
| io_err | output | 1 | Illegal access size at this port |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench uses the default parameters: a 16-bit address, a 3-bit size field and a 32-bit data path, with the port at 0xCF9 and the trigger on bit 2. With the 16-bit address, the bench can present aliases such as 0x1CF9 and 0x8CF9 as well as the neighbouring ports 0xCF8 and 0xCFA. With the 32-bit data path, it can show that write bits above the low byte are dropped and that read bits above the low byte are zero. With the 3-bit size field, every illegal width from 0 to 7 can be presented, including the common 2 and 4.

// File: rtl/sys_reset_port_pkg.sv
package sys_reset_port_pkg;

    localparam int unsigned CTL_W = 8;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;

    localparam logic [CTL_W-1:0] CTL_RESET_VAL = '0;
    localparam logic [CTL_W-1:0] ADVERTISED_RESTART = 8'h06;

endpackage

// File: rtl/sys_reset_port_decode.sv
module sys_reset_port_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SIZE_W    = 3,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              size_err
);
    localparam logic [SIZE_W-1:0] BYTE_SIZE = SIZE_W'(1);

    logic hit;
    logic byte_acc;

    always_comb begin
        hit      = (addr == PORT_ADDR);
        byte_acc = (size == BYTE_SIZE);
        wr_ok    = hit && byte_acc && wr;
        rd_ok    = hit && byte_acc && rd;
        size_err = hit && !byte_acc && (wr || rd);
    end
endmodule

// File: rtl/sys_reset_port_store.sv
module sys_reset_port_store
    import sys_reset_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [CTL_W-1:0] wbyte,
    output logic [CTL_W-1:0] ctl
);
    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            state_d.ctl = wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctl <= CTL_RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl = state_q.ctl;
endmodule

// File: rtl/sys_reset_port_trigger.sv
module sys_reset_port_trigger
    import sys_reset_port_pkg::*;
#(
    parameter int unsigned RST_BIT = 2
) (
    input  logic             wr_ok,
    input  logic [CTL_W-1:0] wbyte,
    output logic             req
);
    always_comb begin
        req = wr_ok && wbyte[RST_BIT];
    end
endmodule

// File: rtl/sys_reset_port.sv
module sys_reset_port
    import sys_reset_port_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int unsigned RST_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [SIZE_W-1:0] io_size,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_err,
    output logic              sys_rst_req
);
    localparam int unsigned PAD_W = DATA_W - CTL_W;

    logic             wr_ok;
    logic             rd_ok;
    logic [CTL_W-1:0] wbyte;
    logic [CTL_W-1:0] ctl;
    logic             unused_wdata_hi;

    assign wbyte           = io_wdata[CTL_W-1:0];
    assign unused_wdata_hi = ^io_wdata[DATA_W-1:CTL_W];

    sys_reset_port_decode #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .PORT_ADDR(PORT_ADDR)
    ) u_decode (
        .addr    (io_addr),
        .size    (io_size),
        .wr      (io_wr),
        .rd      (io_rd),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .size_err(io_err)
    );

    sys_reset_port_store u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_ok(wr_ok),
        .wbyte(wbyte),
        .ctl  (ctl)
    );

    sys_reset_port_trigger #(
        .RST_BIT(RST_BIT)
    ) u_trigger (
        .wr_ok(wr_ok),
        .wbyte(wbyte),
        .req  (sys_rst_req)
    );

    always_comb begin
        io_rdata = '0;
        if (rd_ok) begin
            io_rdata = {{PAD_W{1'b0}}, ctl};
        end
    end
endmodule

// File: rtl/sys_reset_port_chk.sv
module sys_reset_port_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int unsigned RST_BIT   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [SIZE_W-1:0] io_size,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_rdata,
    input logic              io_err,
    input logic              sys_rst_req
);
    localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

    logic legal_rd;
    logic legal_wr;
    assign legal_rd = io_rd && io_addr == PORT_ADDR && io_size == ONE;
    assign legal_wr = io_wr && io_addr == PORT_ADDR && io_size == ONE;

    // R2: a foreign address leaves every output quiet
    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != PORT_ADDR) |-> (!io_err && !sys_rst_req && io_rdata == '0));

    // R3: illegal size at the port gives an error and never a request
    p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == PORT_ADDR && io_size != ONE && (io_rd || io_wr))
        |-> (io_err && !sys_rst_req && io_rdata == '0));

    // R5: a legal read right after a legal write returns the written byte
    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_rd && $past(legal_wr)) |-> (io_rdata[7:0] == $past(io_wdata[7:0])));

    // R4: consecutive legal reads with no write between them agree
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_rd && $past(legal_rd) && !$past(legal_wr)) |-> $stable(io_rdata));

    // R6: a request needs a legal write carrying the trigger bit
    p_req_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (legal_wr && io_wdata[RST_BIT]));

    // R8: a legal write without the trigger bit never requests
    p_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_wr && !io_wdata[RST_BIT]) |-> !sys_rst_req);
endmodule

bind sys_reset_port sys_reset_port_chk #(
    .ADDR_W   (ADDR_W),
    .SIZE_W   (SIZE_W),
    .DATA_W   (DATA_W),
    .PORT_ADDR(PORT_ADDR),
    .RST_BIT  (RST_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_size    (io_size),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .io_err     (io_err),
    .sys_rst_req(sys_rst_req)
);

// File: tb/sys_reset_port_tb.sv
module sys_reset_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [2:0]  io_size = '0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [31:0] io_rdata;
    logic        io_err;
    logic        sys_rst_req;

    int checks = 0;
    int bad = 0;
    int model_byte = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sys_reset_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_size    (io_size),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rd      (io_rd),
        .io_rdata   (io_rdata),
        .io_err     (io_err),
        .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare against the model
    // shortly after, and advance the model at the rising edge.
    task automatic bus(input string tag, input bit rd, input bit wr,
                       input logic [15:0] a, input logic [2:0] sz, input logic [31:0] d);
        bit hit;
        bit legal;
        int exp_rdata;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = a; io_size = sz; io_wdata = d;
        #1;
        hit = (a == 16'hCF9);
        legal = hit && (sz == 3'd1);
        exp_rdata = (legal && rd) ? model_byte : 0;
        check(tag, "rdata", io_rdata, exp_rdata);
        check(tag, "err", io_err, (hit && !legal && (rd || wr)) ? 1 : 0);
        check(tag, "req", sys_rst_req, (legal && wr && d[2]) ? 1 : 0);
        @(posedge clk);
        if (legal && wr) model_byte = int'(d[7:0]);
    endtask

    task automatic idle();
        @(negedge clk);
        io_rd = 0; io_wr = 0; io_addr = '0; io_size = '0; io_wdata = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "req in reset", sys_rst_req, 0);
        check("R1", "err in reset", io_err, 0);
        @(negedge clk); rst_n = 1'b1;
        model_byte = 0;
        bus("R1", 1, 0, 16'hCF9, 3'd1, 0);

        // R5 write then read back, upper bits dropped
        bus("R5", 0, 1, 16'hCF9, 3'd1, 32'hABCD_5A13);
        bus("R5", 1, 0, 16'hCF9, 3'd1, 0);
        bus("R4", 1, 0, 16'hCF9, 3'd1, 0);

        // R2 neighbours and aliases
        bus("R2", 0, 1, 16'hCF8, 3'd1, 32'h04);
        bus("R2", 0, 1, 16'hCFA, 3'd1, 32'h06);
        bus("R2", 1, 1, 16'h1CF9, 3'd1, 32'hFF);
        bus("R2", 1, 0, 16'h8CF9, 3'd1, 0);
        bus("R2", 1, 0, 16'hCF9, 3'd1, 0);

        // R3 every illegal size
        for (int s = 0; s < 8; s++) begin
            if (s != 1) begin
                bus("R3", 0, 1, 16'hCF9, 3'(s), 32'h0000_0006);
                bus("R3", 1, 0, 16'hCF9, 3'(s), 0);
            end
        end
        bus("R3", 1, 0, 16'hCF9, 3'd1, 0);

        // R7 and R8: type bit alone, and trigger clear
        bus("R7", 0, 1, 16'hCF9, 3'd1, 32'h02);
        bus("R7", 1, 0, 16'hCF9, 3'd1, 0);
        bus("R8", 0, 1, 16'hCF9, 3'd1, 32'hFB);
        bus("R8", 1, 0, 16'hCF9, 3'd1, 0);
        bus("R7", 0, 1, 16'hCF9, 3'd1, 32'h04);

        // R6 back-to-back triggers, then a quiet cycle
        bus("R6", 0, 1, 16'hCF9, 3'd1, 32'h04);
        bus("R6", 0, 1, 16'hCF9, 3'd1, 32'h0C);
        bus("R6", 1, 0, 16'hCF9, 3'd1, 0);

        // R9 simultaneous read and write returns old byte
        bus("R9", 1, 1, 16'hCF9, 3'd1, 32'h31);
        bus("R9", 1, 1, 16'hCF9, 3'd1, 32'h42);
        bus("R9", 1, 0, 16'hCF9, 3'd1, 0);

        // R10 advertised restart value
        bus("R10", 0, 1, 16'hCF9, 3'd1, 32'h06);
        bus("R10", 1, 0, 16'hCF9, 3'd1, 0);
        bus("R10", 1, 0, 16'hCF9, 3'd1, 0);

        // R1 reset clears stored byte
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_byte = 0;
        bus("R1", 1, 0, 16'hCF9, 3'd1, 0);
        bus("R1", 0, 0, 16'hCF9, 3'd1, 32'h04);
        idle();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule